// File: doc/BRIEF.md
# Serial Multi-Zone Sensor Scanner

The scanner reads a row of sensor groups through a daisy chain of external parallel-in serial-out shift registers, using only three wires toward the chain: an active-low parallel load, a shift clock and one serial data input. Each scan strobes the load line to freeze every group's inputs, then clocks the whole chain through the controller one bit at a time. It rebuilds each group's byte, most significant bit first, and flags the group as active when that byte is not zero. The result is a zone-active vector with one bit per group.

The same shift clock also drives an external serial-in output port that shows which zones are active. To keep that port from filling with garbage while the sensor chain shifts, the serial output carries the previously published vector in step with every input shift. Each scan then ends with one more full write of the fresh vector. The new vector is published at the port pins and on the block's output in the same cycle, together with a one-cycle done pulse. While enabled, scans repeat back to back with a programmable idle gap. The shift clock half-period is programmable in system clock cycles.

Top module: `zone_scanner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `load_n` is 1, `sck` is 0, `zone_vec` is all zero and `scan_done` is 0.
- R2: Every scan begins with `load_n` held low for exactly `div_cfg`+1 clock cycles, and `sck` is low whenever `load_n` is low.
- R3: Each high phase of `sck` lasts exactly `div_cfg`+1 clock cycles, and a scan produces exactly NUM_GROUPS*GROUP_W + NUM_GROUPS rising edges of `sck` (72 with the defaults), with `sck` low and `load_n` high when `scan_done` pulses.
- R4: `ser_in` is sampled in the clock cycle in which `sck` rises, before the chain shifts. The first bit sampled is the most significant bit of group 0, the group nearest the controller, and each group's byte is assembled by shifting left.
- R5: After a scan, `zone_vec[g]` is 1 exactly when the byte loaded from group g was non-zero. Bit 0 belongs to group 0.
- R6: `zone_vec` changes only in the cycle in which `scan_done` is high, and `scan_done` is high for a single cycle per scan.
- R7: During the input shifts, `sdo` carries the previously published vector, most significant bit first, repeating every NUM_GROUPS shifts. An output port that shifts in `sdo` toward its high end on each `sck` rise therefore holds the old `zone_vec` after every multiple of NUM_GROUPS input shifts.
- R8: The last NUM_GROUPS shifts of a scan write the new vector on `sdo`, most significant bit first. When `scan_done` pulses, the output port holds the new `zone_vec`.
- R9: `sdo` never changes in a cycle in which `sck` rises.
- R10: While `en` stays high, the next scan's `load_n` fall comes `gap_cfg`+1 clock cycles after the `scan_done` pulse.
- R11: Dropping `en` lets the running scan finish with its `scan_done` pulse. After that, `load_n` stays high until `en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Permits new scans to start |
| div_cfg | input | DIV_W | Shift clock half-period minus one, in clock cycles |
| gap_cfg | input | GAP_W | Idle cycles between a scan's end and the next load, minus one |
| ser_in | input | 1 | Serial data from the sensor chain |
| load_n | output | 1 | Active-low parallel load of the sensor chain |
| sck | output | 1 | Shift clock shared by sensor chain and output port |
| sdo | output | 1 | Serial data to the zone indicator port |
| zone_vec | output | NUM_GROUPS | Published zone-active vector, bit 0 nearest group |
| scan_done | output | 1 | One-cycle pulse when a new vector is published |

## Verification
A bit counter that slips by one shows up within a single scan: the wrong group gets flagged in `zone_vec`, the shift-edge total at `scan_done` differs from 72, and the indicator port no longer matches `zone_vec` at that pulse. If `sdo` selection or phase is wrong, the port disagrees with the old vector at the first byte boundary, only eight shift edges into the scan. Divider or gap faults show as the wrong `load_n` low width or wrong `sck` high width on the first phase, or as a load fall at the wrong distance after the done pulse.

// File: rtl/zsc_pkg.sv
package zsc_pkg;
   typedef enum logic [1:0] {
      ST_GAP  = 2'd0,
      ST_LOAD = 2'd1,
      ST_LOW  = 2'd2,
      ST_HIGH = 2'd3
   } zsc_state_e;
endpackage

// File: rtl/zsc_divider.sv
module zsc_divider #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == div_cfg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/zsc_sequencer.sv
module zsc_sequencer
   import zsc_pkg::*;
#(
   parameter int NUM_GROUPS = 8,
   parameter int GROUP_W    = 8,
   parameter int GAP_W      = 16,
   localparam int GRP_CW    = $clog2(NUM_GROUPS + 1),
   localparam int BIT_CW    = $clog2(GROUP_W),
   localparam int OUT_CW    = $clog2(NUM_GROUPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [GAP_W-1:0]  gap_cfg,
   input  logic              tick,
   output logic              run,
   output logic              load_n,
   output logic              sck,
   output logic              sample,
   output logic              write_ph,
   output logic              finish,
   output logic [GRP_CW-1:0] grp_idx,
   output logic [BIT_CW-1:0] bit_idx,
   output logic [OUT_CW-1:0] out_idx
);
   localparam logic [GRP_CW-1:0] GRP_LAST = GRP_CW'(NUM_GROUPS);
   localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(GROUP_W - 1);
   localparam logic [OUT_CW-1:0] OUT_LAST = OUT_CW'(NUM_GROUPS - 1);

   zsc_state_e       state_q;
   logic [GAP_W-1:0] gap_q;

   assign run      = (state_q != ST_GAP);
   assign load_n   = (state_q != ST_LOAD);
   assign sck      = (state_q == ST_HIGH);
   assign write_ph = (grp_idx == GRP_LAST);
   assign sample   = (state_q == ST_LOW) && tick && !write_ph;
   assign finish   = (state_q == ST_HIGH) && tick && write_ph && (out_idx == OUT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_GAP;
         gap_q   <= '0;
         grp_idx <= '0;
         bit_idx <= '0;
         out_idx <= '0;
      end else begin
         unique case (state_q)
            ST_GAP: begin
               if ((gap_q >= gap_cfg) && en) begin
                  state_q <= ST_LOAD;
                  grp_idx <= '0;
                  bit_idx <= '0;
                  out_idx <= '0;
               end else if (gap_q != {GAP_W{1'b1}}) begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            ST_LOAD: begin
               if (tick) state_q <= ST_LOW;
            end
            ST_LOW: begin
               if (tick) state_q <= ST_HIGH;
            end
            ST_HIGH: begin
               if (tick) begin
                  if (finish) begin
                     state_q <= ST_GAP;
                     gap_q   <= '0;
                  end else begin
                     state_q <= ST_LOW;
                     out_idx <= (out_idx == OUT_LAST) ? '0 : out_idx + 1'b1;
                     if (!write_ph) begin
                        if (bit_idx == BIT_LAST) begin
                           bit_idx <= '0;
                           grp_idx <= grp_idx + 1'b1;
                        end else begin
                           bit_idx <= bit_idx + 1'b1;
                        end
                     end
                  end
               end
            end
            default: state_q <= ST_GAP;
         endcase
      end
   end
endmodule

// File: rtl/zsc_assembler.sv
module zsc_assembler #(
   parameter int NUM_GROUPS = 8,
   parameter int GROUP_W    = 8,
   localparam int GRP_CW    = $clog2(NUM_GROUPS + 1),
   localparam int BIT_CW    = $clog2(GROUP_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sample,
   input  logic                  ser_in,
   input  logic [GRP_CW-1:0]     grp_idx,
   input  logic [BIT_CW-1:0]     bit_idx,
   input  logic                  finish,
   output logic [NUM_GROUPS-1:0] pending,
   output logic [NUM_GROUPS-1:0] zone_vec,
   output logic                  scan_done
);
   localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(GROUP_W - 1);

   logic [GROUP_W-1:0] byte_q;
   logic [GROUP_W-1:0] byte_nx;
   logic               byte_end;

   assign byte_nx  = {byte_q[GROUP_W-2:0], ser_in};
   assign byte_end = sample && (bit_idx == BIT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (sample) begin
         byte_q <= byte_nx;
      end
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_zone
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pending[g] <= 1'b0;
         end else if (byte_end && (grp_idx == GRP_CW'(g))) begin
            pending[g] <= |byte_nx;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zone_vec  <= '0;
         scan_done <= 1'b0;
      end else begin
         scan_done <= finish;
         if (finish) zone_vec <= pending;
      end
   end
endmodule

// File: rtl/zsc_port_drv.sv
module zsc_port_drv #(
   parameter int NUM_GROUPS = 8,
   parameter bit MSB_FIRST  = 1'b1,
   localparam int OUT_CW    = $clog2(NUM_GROUPS)
) (
   input  logic                  write_ph,
   input  logic [OUT_CW-1:0]     out_idx,
   input  logic [NUM_GROUPS-1:0] pending,
   input  logic [NUM_GROUPS-1:0] zone_vec,
   output logic                  sdo
);
   logic [OUT_CW-1:0]     sel;
   logic [NUM_GROUPS-1:0] src;

   if (MSB_FIRST) begin : g_msb
      assign sel = OUT_CW'(NUM_GROUPS - 1) - out_idx;
   end else begin : g_lsb
      assign sel = out_idx;
   end

   assign src = write_ph ? pending : zone_vec;
   assign sdo = src[sel];
endmodule

// File: rtl/zone_scanner.sv
module zone_scanner #(
   parameter int NUM_GROUPS = 8,
   parameter int GROUP_W    = 8,
   parameter int DIV_W      = 8,
   parameter int GAP_W      = 16,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en,
   input  logic [DIV_W-1:0]      div_cfg,
   input  logic [GAP_W-1:0]      gap_cfg,
   input  logic                  ser_in,
   output logic                  load_n,
   output logic                  sck,
   output logic                  sdo,
   output logic [NUM_GROUPS-1:0] zone_vec,
   output logic                  scan_done
);
   localparam int GRP_CW = $clog2(NUM_GROUPS + 1);
   localparam int BIT_CW = $clog2(GROUP_W);
   localparam int OUT_CW = $clog2(NUM_GROUPS);

   if (NUM_GROUPS < 2) begin : g_bad_groups
      $error("zone_scanner: NUM_GROUPS must be at least 2");
   end
   if (GROUP_W < 2) begin : g_bad_width
      $error("zone_scanner: GROUP_W must be at least 2");
   end
   if (DIV_W < 1 || GAP_W < 1) begin : g_bad_cfg
      $error("zone_scanner: DIV_W and GAP_W must be positive");
   end

   logic              run;
   logic              tick;
   logic              sample;
   logic              write_ph;
   logic              finish;
   logic [GRP_CW-1:0] grp_idx;
   logic [BIT_CW-1:0] bit_idx;
   logic [OUT_CW-1:0] out_idx;
   logic [NUM_GROUPS-1:0] pending;

   zsc_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .div_cfg (div_cfg),
      .tick    (tick)
   );

   zsc_sequencer #(
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_W    (GROUP_W),
      .GAP_W      (GAP_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .gap_cfg  (gap_cfg),
      .tick     (tick),
      .run      (run),
      .load_n   (load_n),
      .sck      (sck),
      .sample   (sample),
      .write_ph (write_ph),
      .finish   (finish),
      .grp_idx  (grp_idx),
      .bit_idx  (bit_idx),
      .out_idx  (out_idx)
   );

   zsc_assembler #(
      .NUM_GROUPS (NUM_GROUPS),
      .GROUP_W    (GROUP_W)
   ) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (sample),
      .ser_in    (ser_in),
      .grp_idx   (grp_idx),
      .bit_idx   (bit_idx),
      .finish    (finish),
      .pending   (pending),
      .zone_vec  (zone_vec),
      .scan_done (scan_done)
   );

   zsc_port_drv #(
      .NUM_GROUPS (NUM_GROUPS),
      .MSB_FIRST  (MSB_FIRST)
   ) u_port (
      .write_ph (write_ph),
      .out_idx  (out_idx),
      .pending  (pending),
      .zone_vec (zone_vec),
      .sdo      (sdo)
   );
endmodule

// File: rtl/zone_scanner_chk.sv
module zone_scanner_chk #(
   parameter int NUM_GROUPS = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  load_n,
   input logic                  sck,
   input logic                  sdo,
   input logic [NUM_GROUPS-1:0] zone_vec,
   input logic                  scan_done
);
   AST_LOAD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n |-> !sck); // R2

   AST_DONE_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> (!sck && load_n)); // R3

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done); // R6

   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_done |-> $stable(zone_vec)); // R6

   AST_SDO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(sdo)); // R9
endmodule

bind zone_scanner zone_scanner_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_n    (load_n),
   .sck       (sck),
   .sdo       (sdo),
   .zone_vec  (zone_vec),
   .scan_done (scan_done)
);

// File: tb/zone_scanner_tb.sv
module zone_scanner_tb;
   localparam int NG    = 8;
   localparam int GW    = 8;
   localparam int TOTAL = NG * GW;

   typedef struct {
      logic [NG-1:0] vec;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [7:0]    div_cfg = '0;
   logic [15:0]   gap_cfg = '0;
   logic          ser_in;
   logic          load_n, sck, sdo, scan_done;
   logic [NG-1:0] zone_vec;

   logic [TOTAL-1:0] sensors = '0;
   logic [TOTAL-1:0] chain = '0;
   logic [NG-1:0]    port = '0;
   logic             sck_d = 1'b0;
   int               rise_cnt = 0;

   int   checks = 0;
   int   errors = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   zone_scanner u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .div_cfg   (div_cfg),
      .gap_cfg   (gap_cfg),
      .ser_in    (ser_in),
      .load_n    (load_n),
      .sck       (sck),
      .sdo       (sdo),
      .zone_vec  (zone_vec),
      .scan_done (scan_done)
   );

   // external sensor chain and indicator port model
   assign ser_in = chain[TOTAL-1];
   always @(posedge clk) begin
      sck_d <= sck;
      if (!load_n) begin
         chain    <= sensors;
         rise_cnt <= 0;
      end else if (sck && !sck_d) begin
         chain    <= {chain[TOTAL-2:0], 1'b0};
         port     <= {port[NG-2:0], sdo};
         rise_cnt <= rise_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [TOTAL-1:0] pat(input int i);
      logic [TOTAL-1:0] p = '0;
      case (i)
         0: p = '0;
         1: p = '1;
         2: p = 64'h8000_0000_0000_0000;   // group 0 MSB, first bit sampled
         3: p = 64'h0000_0000_0000_0001;   // group 7 LSB, last bit sampled
         4: p = 64'h0100_0100_0100_0100;
         5: for (int g = 0; g < NG; g++) if (g != 3) p[(NG-1-g)*GW + g] = 1'b1;
         6: p = 64'h0000_5a00_0000_0c00;
         default: p = 64'h0100_0000_0000_0000;
      endcase
      return p;
   endfunction

   function automatic logic [NG-1:0] zones(input logic [TOTAL-1:0] p);
      logic [NG-1:0] z;
      for (int g = 0; g < NG; g++) z[g] = |p[(NG-1-g)*GW +: GW];
      return z;
   endfunction

   task automatic push(input int i, input string tag);
      exp_t e;
      sensors = pat(i);
      e.vec = zones(sensors);
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!scan_done);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // monitor / scoreboard
   initial begin
      int   cyc = 0, done_cyc = 0, load_w = 0, high_w = 0, prev_rise = 0;
      bit   wait_load = 0, en_low_seen = 0, prev_load_n = 1;
      exp_t e;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (scan_done) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R6 unexpected done", 1, 0);
               end else begin
                  e = q.pop_front();
                  chk(zone_vec == e.vec, e.tag, zone_vec, e.vec);   // R5 / R4
                  chk(port == zone_vec, "R8", port, zone_vec);
                  chk(rise_cnt == TOTAL + NG, "R3", rise_cnt, TOTAL + NG);
               end
               done_cyc = cyc; wait_load = 1; en_low_seen = 0;
            end
            if (!en) en_low_seen = 1;
            if (!load_n) begin
               load_w++;
               if (prev_load_n && wait_load) begin
                  if (!en_low_seen) chk(cyc - done_cyc == gap_cfg + 1, "R10", cyc - done_cyc, gap_cfg + 1);
                  wait_load = 0;
               end
            end else if (!prev_load_n) begin
               chk(load_w == div_cfg + 1, "R2", load_w, div_cfg + 1);
               load_w = 0;
            end
            if (sck) high_w++;
            else if (high_w != 0) begin
               chk(high_w == div_cfg + 1, "R3", high_w, div_cfg + 1);
               high_w = 0;
            end
            if (rise_cnt != prev_rise) begin
               prev_rise = rise_cnt;
               if (rise_cnt % NG == 0 && rise_cnt > 0 && rise_cnt <= TOTAL)
                  chk(port == zone_vec, "R7", port, zone_vec);
            end
         end
         prev_load_n = load_n;
      end
   end

   // driver
   initial begin
      int loads;
      logic [NG-1:0] held;
      repeat (4) @(negedge clk);
      chk(load_n == 1'b1 && sck == 1'b0, "R1 lines", {load_n, sck}, 2'b10);
      chk(zone_vec == '0 && scan_done == 1'b0, "R1 outputs", {zone_vec, scan_done}, 0);
      push(0, "R5");
      rst_n = 1'b1;
      @(negedge clk);
      chk(load_n == 1'b1 && zone_vec == '0, "R1 after release", {load_n, zone_vec}, {1'b1, 8'h00});
      en = 1'b1;
      for (int i = 1; i <= 6; i++) begin
         wait_done();
         if (i >= 4 && i <= 5) begin div_cfg = 8'd2; gap_cfg = 16'd5; end
         if (i == 6)           begin div_cfg = 8'd1; gap_cfg = 16'd3; end
         push(i, (i == 2 || i == 3) ? "R4" : "R5");
      end
      // R11: drop enable in the middle of the scan of pattern 6
      while (load_n) @(negedge clk);
      repeat (20) @(negedge clk);
      en = 1'b0;
      wait_done();
      held = zone_vec;
      div_cfg = 8'd0; gap_cfg = 16'd2;
      loads = 0;
      repeat (200) begin
         @(negedge clk);
         if (!load_n) loads++;
      end
      chk(loads == 0, "R11 no load while disabled", loads, 0);
      chk(zone_vec == held, "R11 vector held", zone_vec, held);
      push(7, "R11");
      en = 1'b1;
      wait_done();
      repeat (4) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end
endmodule